// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block gates power to a set of on-chip domains under software control. Software first marks the target domains in one of two selection registers: one for domains to power up and one for domains to power down. It then writes a short byte sequence to a single command register. A small parser checks this sequence. It must open with a reset byte, followed by a two-byte pattern. The pattern differs for power-up and power-down, and the low byte comes first.

Once a command is accepted, a sequencer visits the selected domains in ascending index order. On power-up it closes a domain's switch and waits for that domain's power-good input. It then waits a settle count, releases isolation and sets the domain's state bit. Power-down runs in reverse. Completion, malformed commands and power-good timeouts are recorded in two write-one-to-clear status registers. These drive one level interrupt through a mask register.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset, the power state register (0x80) reads 0x03. Switch outputs are 0x03, isolation outputs are 0x7C, the mask (0x48) reads 0x1FF, both status registers (0x88, 0x8C) read 0, and the interrupt is low.
- R2: The power-up selection register (0x0C) and the power-down selection register (0x10) each hold 7 bits, one per domain with bit i for domain i. They read back the low 7 bits written.
- R3: Writing 0xFF, then 0x05, then 0x50 to the command register (0x44) powers up every selected domain that is off. The switch closes, the domain's power-good is awaited, isolation is released, and state bit i becomes 1. Status bit 0 (done) is then set.
- R4: Writing 0xFF, then 0x0A, then 0xA0 powers down every domain selected in 0x10. Isolation is asserted, then the switch opens, then state bit i is cleared. Status bit 0 is then set.
- R5: Domains 0 and 1 are always-on. A power-down command never clears their state, switch or isolation release.
- R6: A byte other than the expected one aborts the command without any domain change and sets status bit 2. Any non-0xFF byte written while no sequence has been started counts as such a byte. A 0xFF byte restarts parsing at any point.
- R7: If power-good does not arrive within the timeout (default 5000 cycles, 100 us at 50 MHz), the sequence stops. Status bit 3 is set, the switch reopens, isolation stays on, the state bit stays 0, and bit 0 is not set.
- R8: Writing ones to 0x8C or 0x88 clears those bits in that register only. Both registers record the same events.
- R9: A mask bit of 1 suppresses its interrupt-status bit. The interrupt output is the OR of all interrupt-status bits whose mask bit is 0.
- R10: Isolation is asserted for every domain whose switch is open. Selected domains are processed one at a time, lowest index first.
- R11: A selected domain already in the requested state is skipped, and the command still sets the done bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| dom_pgood_i | input | 7 | Power-good feedback, one per domain |
| dom_switch_o | output | 7 | Power switch enable, one per domain |
| dom_iso_o | output | 7 | Isolation enable, one per domain |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest state to reach is a power-good timeout in the middle of a sequence. No ordinary register access causes one, because the domain has to stay dark for the whole timeout window. The bench therefore models power-good as a one-cycle-delayed copy of the switch output, with a per-domain kill mask that can hold one domain dark for over 5000 cycles. Command-ordering faults need their own setup as well: a mis-ordered byte after a valid reset, a command with no reset byte, and a reset byte inserted halfway through a valid command.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
    localparam logic [7:0] ADR_ON_SEL  = 8'h0C;
    localparam logic [7:0] ADR_OFF_SEL = 8'h10;
    localparam logic [7:0] ADR_CMD     = 8'h44;
    localparam logic [7:0] ADR_MASK    = 8'h48;
    localparam logic [7:0] ADR_STATE   = 8'h80;
    localparam logic [7:0] ADR_EVT     = 8'h88;
    localparam logic [7:0] ADR_IST     = 8'h8C;

    localparam logic [7:0] BYTE_RESTART = 8'hFF;
    localparam logic [7:0] BYTE_ON_LO   = 8'h05;
    localparam logic [7:0] BYTE_ON_HI   = 8'h50;
    localparam logic [7:0] BYTE_OFF_LO  = 8'h0A;
    localparam logic [7:0] BYTE_OFF_HI  = 8'hA0;

    localparam int unsigned STAT_W   = 9;
    localparam int unsigned BIT_DONE = 0;
    localparam int unsigned BIT_BAD  = 2;
    localparam int unsigned BIT_TMO  = 3;

    typedef enum logic [1:0] {P_IDLE, P_ARMED, P_ON_LO, P_OFF_LO} parse_st_e;
    typedef enum logic [2:0] {S_IDLE, S_SCAN, S_WAIT_PG, S_SETTLE, S_OFF_SW, S_OFF_CLR} seq_st_e;
endpackage

// File: rtl/pwr_cmd_parser.sv
module pwr_cmd_parser
    import pwr_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    input  logic       busy,
    output logic       start_on,
    output logic       start_off,
    output logic       bad_cmd
);
    typedef struct packed {
        parse_st_e st;
        logic      on;
        logic      off;
        logic      bad;
    } prs_t;

    prs_t prs_d, prs_q;

    always_comb begin
        prs_d     = prs_q;
        prs_d.on  = 1'b0;
        prs_d.off = 1'b0;
        prs_d.bad = 1'b0;
        if (cmd_we) begin
            if (cmd_byte == BYTE_RESTART) begin
                prs_d.st = P_ARMED;
            end else begin
                prs_d.st = P_IDLE;
                unique case (prs_q.st)
                    P_ARMED: begin
                        if (cmd_byte == BYTE_ON_LO)       prs_d.st = P_ON_LO;
                        else if (cmd_byte == BYTE_OFF_LO) prs_d.st = P_OFF_LO;
                        else                              prs_d.bad = 1'b1;
                    end
                    P_ON_LO: begin
                        if (cmd_byte == BYTE_ON_HI && !busy) prs_d.on  = 1'b1;
                        else                                 prs_d.bad = 1'b1;
                    end
                    P_OFF_LO: begin
                        if (cmd_byte == BYTE_OFF_HI && !busy) prs_d.off = 1'b1;
                        else                                  prs_d.bad = 1'b1;
                    end
                    default: prs_d.bad = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prs_q <= '{st: P_IDLE, on: 1'b0, off: 1'b0, bad: 1'b0};
        end else begin
            prs_q <= prs_d;
        end
    end

    assign start_on  = prs_q.on;
    assign start_off = prs_q.off;
    assign bad_cmd   = prs_q.bad;

    // R6: one outcome per parsed byte
    a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({prs_q.on, prs_q.off, prs_q.bad}));
endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq
    import pwr_seq_pkg::*;
#(
    parameter int unsigned NUM_DOM     = 7,
    parameter int unsigned NUM_AON     = 2,
    parameter int unsigned TIMEOUT_CYC = 5000,
    parameter int unsigned SETTLE_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_on,
    input  logic               start_off,
    input  logic [NUM_DOM-1:0] on_sel,
    input  logic [NUM_DOM-1:0] off_sel,
    input  logic [NUM_DOM-1:0] pgood,
    output logic               busy,
    output logic [NUM_DOM-1:0] sw,
    output logic [NUM_DOM-1:0] iso,
    output logic [NUM_DOM-1:0] pwr,
    output logic               done,
    output logic               tmo_fail
);
    localparam int unsigned IW    = $clog2(NUM_DOM + 1);
    localparam int unsigned CMAX  = (TIMEOUT_CYC > SETTLE_CYC) ? TIMEOUT_CYC : SETTLE_CYC;
    localparam int unsigned CW    = $clog2(CMAX + 1);
    localparam logic [NUM_DOM-1:0] AON_MASK = NUM_DOM'((1 << NUM_AON) - 1);

    typedef struct packed {
        seq_st_e            st;
        logic               dir_on;
        logic [NUM_DOM-1:0] mask;
        logic [NUM_DOM-1:0] sw;
        logic [NUM_DOM-1:0] iso;
        logic [NUM_DOM-1:0] pwr;
        logic [IW-1:0]      idx;
        logic [CW-1:0]      cnt;
        logic               done;
        logic               fail;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.fail = 1'b0;
        unique case (seq_q.st)
            S_IDLE: begin
                if (start_on || start_off) begin
                    seq_d.st     = S_SCAN;
                    seq_d.dir_on = start_on;
                    seq_d.mask   = start_on ? on_sel : (off_sel & ~AON_MASK);
                    seq_d.idx    = '0;
                end
            end
            S_SCAN: begin
                if (seq_q.idx == IW'(NUM_DOM)) begin
                    seq_d.done = 1'b1;
                    seq_d.st   = S_IDLE;
                end else if (seq_q.mask[seq_q.idx] && (seq_q.dir_on != seq_q.pwr[seq_q.idx])) begin
                    if (seq_q.dir_on) begin
                        seq_d.sw[seq_q.idx] = 1'b1;
                        seq_d.cnt           = '0;
                        seq_d.st            = S_WAIT_PG;
                    end else begin
                        seq_d.iso[seq_q.idx] = 1'b1;
                        seq_d.st             = S_OFF_SW;
                    end
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            S_WAIT_PG: begin
                if (pgood[seq_q.idx]) begin
                    seq_d.cnt = '0;
                    seq_d.st  = S_SETTLE;
                end else if (seq_q.cnt == CW'(TIMEOUT_CYC - 1)) begin
                    seq_d.sw[seq_q.idx] = 1'b0;
                    seq_d.fail          = 1'b1;
                    seq_d.st            = S_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            S_SETTLE: begin
                if (!pgood[seq_q.idx]) begin
                    seq_d.cnt = '0;
                    seq_d.st  = S_WAIT_PG;
                end else if (seq_q.cnt == CW'(SETTLE_CYC - 1)) begin
                    seq_d.iso[seq_q.idx] = 1'b0;
                    seq_d.pwr[seq_q.idx] = 1'b1;
                    seq_d.idx            = seq_q.idx + 1'b1;
                    seq_d.st             = S_SCAN;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            S_OFF_SW: begin
                seq_d.sw[seq_q.idx] = 1'b0;
                seq_d.st            = S_OFF_CLR;
            end
            S_OFF_CLR: begin
                seq_d.pwr[seq_q.idx] = 1'b0;
                seq_d.idx            = seq_q.idx + 1'b1;
                seq_d.st             = S_SCAN;
            end
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: S_IDLE, dir_on: 1'b0, mask: '0, sw: AON_MASK, iso: ~AON_MASK,
                       pwr: AON_MASK, idx: '0, cnt: '0, done: 1'b0, fail: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy     = (seq_q.st != S_IDLE);
    assign sw       = seq_q.sw;
    assign iso      = seq_q.iso;
    assign pwr      = seq_q.pwr;
    assign done     = seq_q.done;
    assign tmo_fail = seq_q.fail;

    // R10: an open switch always comes with isolation
    a_r10_iso_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        (~seq_q.iso & ~seq_q.sw) == '0);
    // R5: always-on domains keep their state
    a_r5_aon_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.pwr & AON_MASK) == AON_MASK);
    // R3: isolation is released only where power-good was present
    a_r3_release_on_pg: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(seq_q.iso) & ~seq_q.iso) & ~$past(pgood)) == '0);
    // R7: a timeout never reports completion in the same cycle
    a_r7_fail_not_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_q.done && seq_q.fail));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int unsigned NUM_DOM     = 7,
    parameter int unsigned NUM_AON     = 2,
    parameter int unsigned TIMEOUT_CYC = 5000,
    parameter int unsigned SETTLE_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_DOM-1:0] dom_pgood_i,
    output logic [NUM_DOM-1:0] dom_switch_o,
    output logic [NUM_DOM-1:0] dom_iso_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [NUM_DOM-1:0] on_sel;
        logic [NUM_DOM-1:0] off_sel;
        logic [STAT_W-1:0]  mask;
        logic [STAT_W-1:0]  evt;
        logic [STAT_W-1:0]  ist;
    } reg_t;

    reg_t reg_d, reg_q;

    logic               wr;
    logic               start_on, start_off, bad_cmd, busy, done, tmo_fail;
    logic [NUM_DOM-1:0] pwr;
    logic [STAT_W-1:0]  events;

    assign wr = bus_sel && bus_we;

    pwr_cmd_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (wr && (bus_addr == ADR_CMD)),
        .cmd_byte  (bus_wdata[7:0]),
        .busy      (busy),
        .start_on  (start_on),
        .start_off (start_off),
        .bad_cmd   (bad_cmd)
    );

    pwr_dom_seq #(
        .NUM_DOM     (NUM_DOM),
        .NUM_AON     (NUM_AON),
        .TIMEOUT_CYC (TIMEOUT_CYC),
        .SETTLE_CYC  (SETTLE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_on  (start_on),
        .start_off (start_off),
        .on_sel    (reg_q.on_sel),
        .off_sel   (reg_q.off_sel),
        .pgood     (dom_pgood_i),
        .busy      (busy),
        .sw        (dom_switch_o),
        .iso       (dom_iso_o),
        .pwr       (pwr),
        .done      (done),
        .tmo_fail  (tmo_fail)
    );

    always_comb begin
        events           = '0;
        events[BIT_DONE] = done;
        events[BIT_BAD]  = bad_cmd;
        events[BIT_TMO]  = tmo_fail;
    end

    always_comb begin
        reg_d = reg_q;
        if (wr && bus_addr == ADR_ON_SEL)  reg_d.on_sel  = bus_wdata[NUM_DOM-1:0];
        if (wr && bus_addr == ADR_OFF_SEL) reg_d.off_sel = bus_wdata[NUM_DOM-1:0];
        if (wr && bus_addr == ADR_MASK)    reg_d.mask    = bus_wdata[STAT_W-1:0];
        if (wr && bus_addr == ADR_IST)     reg_d.ist     = reg_q.ist & ~bus_wdata[STAT_W-1:0];
        if (wr && bus_addr == ADR_EVT)     reg_d.evt     = reg_q.evt & ~bus_wdata[STAT_W-1:0];
        reg_d.ist = reg_d.ist | events;
        reg_d.evt = reg_d.evt | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '{on_sel: '0, off_sel: '0, mask: '1, evt: '0, ist: '0};
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_ON_SEL:  bus_rdata[NUM_DOM-1:0] = reg_q.on_sel;
            ADR_OFF_SEL: bus_rdata[NUM_DOM-1:0] = reg_q.off_sel;
            ADR_MASK:    bus_rdata[STAT_W-1:0]  = reg_q.mask;
            ADR_STATE:   bus_rdata[NUM_DOM-1:0] = pwr;
            ADR_EVT:     bus_rdata[STAT_W-1:0]  = reg_q.evt;
            ADR_IST:     bus_rdata[STAT_W-1:0]  = reg_q.ist;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_o = |(reg_q.ist & ~reg_q.mask);

    // R8: a one written to the done bit clears it unless a new completion lands
    a_r8_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADR_IST && bus_wdata[BIT_DONE] && !done) |=> !reg_q.ist[BIT_DONE]);
    // R6: a rejected byte is recorded in both status registers
    a_r6_bad_logged: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> (reg_q.ist[BIT_BAD] && reg_q.evt[BIT_BAD]));
endmodule

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [6:0]  pgood = 7'h03;
    logic [6:0]  dead = 7'h00;
    logic [6:0]  sw_o, iso_o;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;

    always #10 clk = ~clk;

    always @(posedge clk) pgood <= sw_o & ~dead;

    pwr_seq_ctrl u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .dom_pgood_i  (pgood),
        .dom_switch_o (sw_o),
        .dom_iso_o    (iso_o),
        .irq_o        (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr_status();
        wr(8'h8C, 32'h1FF);
        wr(8'h88, 32'h1FF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h80, v); chk("R1 state", v, 32'h03);
        chk("R1 switch", {25'd0, sw_o}, 32'h03);
        chk("R1 iso", {25'd0, iso_o}, 32'h7C);
        rd(8'h48, v); chk("R1 mask", v, 32'h1FF);
        rd(8'h8C, v); chk("R1 int status", v, 32'h0);
        rd(8'h88, v); chk("R1 event status", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);
    endtask

    task automatic t_select();
        logic [31:0] v;
        wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, v); chk("R2 on select", v, 32'h7F);
        wr(8'h10, 32'h55);        rd(8'h10, v); chk("R2 off select", v, 32'h55);
    endtask

    task automatic t_power_on();
        logic [31:0] v;
        int t2, t4;
        t2 = -1; t4 = -1;
        wr(8'h0C, 32'h14);
        wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h50);
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (sw_o[2] && t2 < 0) t2 = c;
            if (sw_o[4] && t4 < 0) t4 = c;
            if (!sw_o[2] && iso_o[2] !== 1'b1) chk("R10 iso while open", 32'h0, 32'h1);
        end
        chk("R10 ascending order", {31'd0, (t2 >= 0 && t4 > t2)}, 32'h1);
        rd(8'h80, v); chk("R3 state after on", v, 32'h17);
        chk("R3 switch", {25'd0, sw_o}, 32'h17);
        chk("R3 iso released", {25'd0, iso_o}, 32'h68);
        rd(8'h8C, v); chk("R3 done bit", v, 32'h1);
    endtask

    task automatic t_irq_w1c();
        logic [31:0] v;
        chk("R9 masked irq", {31'd0, irq}, 32'h0);
        wr(8'h48, 32'h1FE);
        chk("R9 unmasked irq", {31'd0, irq}, 32'h1);
        wr(8'h8C, 32'h1);
        rd(8'h8C, v); chk("R8 int cleared", v, 32'h0);
        rd(8'h88, v); chk("R8 event kept", v, 32'h1);
        chk("R9 irq after clear", {31'd0, irq}, 32'h0);
        wr(8'h88, 32'h1);
        rd(8'h88, v); chk("R8 event cleared", v, 32'h0);
    endtask

    task automatic t_skip();
        logic [31:0] v;
        wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h50);
        idle(30);
        rd(8'h80, v); chk("R11 state unchanged", v, 32'h17);
        rd(8'h8C, v); chk("R11 done set", v, 32'h1);
        chk("R9 irq on done", {31'd0, irq}, 32'h1);
        clr_status();
    endtask

    task automatic t_power_off();
        logic [31:0] v;
        wr(8'h10, 32'h07);
        wr(8'h44, 32'hFF); wr(8'h44, 32'h0A); wr(8'h44, 32'hA0);
        idle(40);
        rd(8'h80, v); chk("R4 state after off", v, 32'h13);
        chk("R4 switch open", {31'd0, sw_o[2]}, 32'h0);
        chk("R4 iso on", {31'd0, iso_o[2]}, 32'h1);
        chk("R5 aon switches", {30'd0, sw_o[1:0]}, 32'h3);
        chk("R5 aon iso", {30'd0, iso_o[1:0]}, 32'h0);
        rd(8'h8C, v); chk("R4 done", v, 32'h1);
        clr_status();
    endtask

    task automatic t_bad_seq();
        logic [31:0] v;
        wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'hA0);
        idle(20);
        rd(8'h80, v); chk("R6 wrong high byte no change", v, 32'h13);
        rd(8'h8C, v); chk("R6 failure bit", v, 32'h4);
        clr_status();
        wr(8'h44, 32'h05); wr(8'h44, 32'h50);
        idle(20);
        rd(8'h80, v); chk("R6 missing restart no change", v, 32'h13);
        rd(8'h88, v); chk("R6 failure event", v, 32'h4);
        clr_status();
        wr(8'h0C, 32'h04);
        wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'hFF);
        wr(8'h44, 32'h05); wr(8'h44, 32'h50);
        idle(40);
        rd(8'h80, v); chk("R6 restart mid command", v, 32'h17);
        rd(8'h8C, v); chk("R6 restart no failure", v, 32'h1);
        clr_status();
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        dead = 7'h20;
        wr(8'h0C, 32'h20);
        wr(8'h44, 32'hFF); wr(8'h44, 32'h05); wr(8'h44, 32'h50);
        idle(5200);
        rd(8'h8C, v); chk("R7 timeout bit no done", v, 32'h8);
        rd(8'h80, v); chk("R7 state bit clear", v, 32'h17);
        chk("R7 switch reopened", {31'd0, sw_o[5]}, 32'h0);
        chk("R7 iso held", {31'd0, iso_o[5]}, 32'h1);
        dead = 7'h00;
        clr_status();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_select();
        wr(8'h10, 32'h00);
        t_power_on();
        t_irq_w1c();
        t_skip();
        t_power_off();
        t_bad_seq();
        t_timeout();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule